// File: doc/BRIEF.md
# Inter-Processor and Interval Timer Interrupt Unit

This unit holds one 64-bit control/status word and one skip counter per CPU. From them it drives a per-CPU inter-processor interrupt line and a per-CPU interval-timer interrupt line. Software reaches both through a simple register port: a write strobe, a read strobe, a 12-bit byte offset, 64-bit write data and the index of the CPU that issues the access.

Different fields of the control word react to a write in different ways. Some bits clear when 1 is written to them. A group of request bits sets the inter-processor status bits. One four-bit field accepts new ones only while it is all zero. A single override bit wipes a whole byte. One nibble is ordinary read/write storage.

A shared timer tick input is edge-detected inside the unit. Each rising edge decrements every CPU's skip counter. Once a counter has wrapped below zero, every later tick raises that CPU's interval-timer status bit, until software rewrites the counter.

Top module: `ipi_timer_unit`

## Requirements
- R1: After reset, the control word reads 0x0000_0008_0000_0000 (bit 35 set) with the reading CPU's index in bits 1:0. Every skip counter reads 0. Both interrupt outputs are 0.
- R2: In a control-word write (offset 0x080), a 1 in any of bits 11:4 or in bit 28 clears that stored bit. A 0 leaves the bit unchanged.
- R3: In a control-word write, a 1 in bit 12+i sets IPI status bit 8+i. This set is applied after the clear of R2, so a write that both clears and sets a bit leaves it at 1.
- R4: A control-word write with bit 20 at 1 forces stored bits 23:16 to 0, whatever the other write bits hold.
- R5: A control-word write with bit 20 at 0 ORs write bits 23:20 into the stored bits 23:20. It ORs write bits 19:16 into stored bits 19:16 only when those stored bits are currently all zero.
- R6: Stored bits 43:40 take write bits 43:40 directly. Every other bit not named in R2 to R5 ignores writes.
- R7: A read returns its data one cycle after the read strobe, with a valid flag. A control-word read shows bits 1:0 as the reading CPU's index. Unmapped offsets read as 0.
- R8: ipi_o[i] equals status bit 8+i and iti_o[i] equals status bit 4+i. A register write can clear an ITI bit but never set one.
- R9: A write to CPU i's counter (offsets 0x380, 0x3C0, 0x700, 0x740 for CPU 0..3) stores write bits 23:0 and clears overflow bit 24. A read returns the 25-bit value {overflow, count}.
- R10: On each rising edge of the tick, every counter decrements modulo 2^25, and bit 24 stays set once set. If bit 24 of the new value is set, ITI status bit 4+i is set.
- R11: A tick held high, or a falling tick edge, changes neither the counters nor the ITI bits.
- R12: When a tick edge and a register write fall in the same cycle, the write is applied on top of the tick's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 64 | Write data |
| bus_cpu | input | 2 | Index of the accessing CPU |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tick_in | input | 1 | Shared periodic timer level |
| ipi_o | output | 4 | Per-CPU inter-processor interrupt |
| iti_o | output | 4 | Per-CPU interval-timer interrupt |

## Verification
The assertions assume that the write strobe and the tick are the only causes of state change. An ITI bit may rise only in a cycle where some counter reports an overflowed tick. The IPI bits may move only under a write. The stimulus keeps every access to one cycle and never mixes a read with a write. It drives tick pulses with at least one low cycle between them, apart from a deliberate long high level that exercises the edge detector. It combines a tick with a write only in the two cases aimed at write-after-tick ordering.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_CTL = 12'h080;
  localparam logic [63:0] CTL_RESET = 64'h0000_0008_0000_0000;

  // field positions of the control word (decoded by CPU-side software)
  localparam int ITI_LO  = 4;
  localparam int IPI_LO  = 8;
  localparam int REQ_LO  = 12;
  localparam int WID_LO  = 16;
  localparam int TOP_LO  = 20;
  localparam int WIPE_B  = 20;
  localparam int ERR_B   = 28;
  localparam int RW_LO   = 40;

  // counter offset for CPU i: two pairs in separate 64-byte strides
  function automatic logic [ADDR_W-1:0] ctr_ofs(input int i);
    if (i < 2) ctr_ofs = ADDR_W'(12'h380 + 12'h040 * i);
    else       ctr_ofs = ADDR_W'(12'h700 + 12'h040 * (i - 2));
  endfunction
endpackage

// File: rtl/ipi_skip_ctr.sv
module ipi_skip_ctr #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W:0]   val,
  output logic             fire
);
  localparam int VW = CNT_W + 1;

  logic [CNT_W:0] dec;
  logic           dec_ovf;

  always_comb begin
    dec     = val - VW'(1);
    dec_ovf = dec[CNT_W] | val[CNT_W];
    fire    = rise & dec_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else if (wr) begin
      val <= {1'b0, wdata};
    end else if (rise) begin
      val <= {dec_ovf, dec[CNT_W-1:0]};
    end
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && val[CNT_W]) |=> val[CNT_W]);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise && !wr) |=> $stable(val));
  // R9
  wr_clears_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> !val[CNT_W]);
endmodule

// File: rtl/ipi_ctl_reg.sv
module ipi_ctl_reg
  import ipi_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [63:0]     wd,
  input  logic [NCPU-1:0] fire,
  output logic [63:0]     q
);
  localparam int NIB = NCPU;

  logic [63:0] nxt;

  always_comb begin
    nxt = q;
    // tick result first
    nxt[ITI_LO +: NIB] = q[ITI_LO +: NIB] | fire;
    if (wr) begin
      nxt[ITI_LO +: NIB] = nxt[ITI_LO +: NIB] & ~wd[ITI_LO +: NIB];
      nxt[IPI_LO +: NIB] = nxt[IPI_LO +: NIB] & ~wd[IPI_LO +: NIB];
      nxt[ERR_B]         = nxt[ERR_B] & ~wd[ERR_B];
      if (wd[WIPE_B]) begin
        nxt[WID_LO +: 8] = '0;
      end else begin
        nxt[TOP_LO +: 4] = nxt[TOP_LO +: 4] | wd[TOP_LO +: 4];
        if (nxt[WID_LO +: 4] == 4'h0)
          nxt[WID_LO +: 4] = wd[WID_LO +: 4];
      end
      nxt[IPI_LO +: NIB] = nxt[IPI_LO +: NIB] | wd[REQ_LO +: NIB];
      nxt[RW_LO +: 4]    = wd[RW_LO +: 4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= CTL_RESET;
    else     q <= nxt;
  end

  // R8
  ipi_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q[IPI_LO +: NIB]));
  // R8
  iti_rise_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !(|fire) |=> ((q[ITI_LO +: NIB] & ~$past(q[ITI_LO +: NIB])) == '0));
  // R4
  wipe_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wd[WIPE_B]) |=> (q[WID_LO +: 8] == 8'h00));
endmodule

// File: rtl/ipi_timer_unit.sv
module ipi_timer_unit
  import ipi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  input  logic [1:0]        bus_cpu,
  output logic [63:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              tick_in,
  output logic [NCPU-1:0]   ipi_o,
  output logic [NCPU-1:0]   iti_o
);
  localparam int VW  = CNT_W + 1;
  localparam int PAD = 64 - VW;

  logic            tick_q;
  logic            rise;
  logic [NCPU-1:0] fire;
  logic [NCPU-1:0] ctr_wr;
  logic [CNT_W:0]  ctr_val [NCPU];
  logic [63:0]     ctl_q;
  logic            ctl_wr;
  logic [63:0]     rd_mux;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick_in;
  end
  assign rise   = tick_in & ~tick_q;
  assign ctl_wr = bus_wr && (bus_addr == OFS_CTL);

  for (genvar i = 0; i < NCPU; i++) begin : g_ctr
    assign ctr_wr[i] = bus_wr && (bus_addr == ctr_ofs(i));
    ipi_skip_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .rise  (rise),
      .wr    (ctr_wr[i]),
      .wdata (bus_wdata[CNT_W-1:0]),
      .val   (ctr_val[i]),
      .fire  (fire[i])
    );
  end

  ipi_ctl_reg #(.NCPU(NCPU)) u_ctl (
    .clk  (clk),
    .rst  (rst),
    .wr   (ctl_wr),
    .wd   (bus_wdata),
    .fire (fire),
    .q    (ctl_q)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_CTL) rd_mux = {ctl_q[63:2], bus_cpu};
    for (int i = 0; i < NCPU; i++) begin
      if (bus_addr == ctr_ofs(i)) rd_mux = {{PAD{1'b0}}, ctr_val[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign ipi_o = ctl_q[IPI_LO +: NCPU];
  assign iti_o = ctl_q[ITI_LO +: NCPU];
endmodule

// File: tb/ipi_timer_unit_tb.sv
module ipi_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [1:0]  bus_cpu = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic        tick_in = 1'b0;
  logic [3:0]  ipi_o, iti_o;

  int checks = 0, fails = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  ipi_timer_unit u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tick_in(tick_in),
    .ipi_o(ipi_o), .iti_o(iti_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each read response
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) check("R7 unexpected rvalid", 64'd1, 64'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  // one bus cycle; tick level t held during it, dropped after unless keep
  task automatic cyc(input bit w, input logic [11:0] a, input logic [63:0] d, input bit t);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; tick_in = t;
    @(negedge clk);
    bus_wr = 1'b0; tick_in = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic tick();
    cyc(1'b0, 12'h000, 64'd0, 1'b1);
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] c, input logic [63:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_cpu = c;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ipi", {60'd0, ipi_o}, 64'd0);
    check("R1 iti", {60'd0, iti_o}, 64'd0);
    rd(12'h080, 2'd2, 64'h0000_0008_0000_0002, "R1 ctl reset");
    rd(12'h380, 2'd0, 64'd0, "R1 ctr0 reset");

    // R3 request bits set IPI status
    wr(12'h080, 64'h0000_0000_0000_F000);
    check("R3 R8 ipi set", {60'd0, ipi_o}, 64'hF);
    rd(12'h080, 2'd1, 64'h0000_0008_0000_0F01, "R7 cpu index");
    // R2 W1C
    wr(12'h080, 64'h0000_0000_0000_0300);
    check("R2 ipi w1c", {60'd0, ipi_o}, 64'hC);
    // R3 clear then set same bit -> stays set
    wr(12'h080, 64'h0000_0000_0000_4400);
    check("R3 set after clear", {60'd0, ipi_o}, 64'hC);
    wr(12'h080, 64'h0000_0000_0000_0C00);
    check("R2 ipi cleared", {60'd0, ipi_o}, 64'h0);

    // R5 / R4
    wr(12'h080, 64'h0000_0000_00A5_0000);
    rd(12'h080, 2'd0, 64'h0000_0008_00A5_0000, "R5 or both");
    wr(12'h080, 64'h0000_0000_0042_0000);
    rd(12'h080, 2'd0, 64'h0000_0008_00E5_0000, "R5 low only if zero");
    wr(12'h080, 64'h0000_0000_0013_0000);
    rd(12'h080, 2'd0, 64'h0000_0008_0000_0000, "R4 wipe");

    // R6 plain rw nibble, other bits ignored
    wr(12'h080, 64'h0000_0A00_1000_0003);
    rd(12'h080, 2'd0, 64'h0000_0A08_0000_0000, "R6 rw nibble");
    wr(12'h080, 64'hF000_0500_0000_000F);
    rd(12'h080, 2'd3, 64'h0000_0508_0000_0003, "R6 rw rewrite");
    rd(12'h040, 2'd1, 64'd0, "R7 unmapped");

    // R9 counters
    wr(12'h3C0, 64'h0000_0000_FF00_0002);
    rd(12'h3C0, 2'd0, 64'h2, "R9 low 24 bits");
    wr(12'h380, 64'h0);
    wr(12'h700, 64'h1);
    wr(12'h740, 64'h0012_3456);

    // R10 ticks
    tick();
    check("R10 iti t1", {60'd0, iti_o}, 64'h1);
    rd(12'h380, 2'd0, 64'h1FF_FFFF, "R10 wrap");
    tick();
    check("R10 iti t2", {60'd0, iti_o}, 64'h5);
    // R11 held high: single edge
    @(negedge clk); tick_in = 1'b1;
    repeat (4) @(negedge clk);
    tick_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 iti held", {60'd0, iti_o}, 64'h7);
    rd(12'h3C0, 2'd0, 64'h1FF_FFFF, "R11 ctr1 one step");
    rd(12'h740, 2'd0, 64'h12_3453, "R11 ctr3 one step");
    // R10 sticky refire
    wr(12'h080, 64'h10);
    check("R2 iti w1c", {60'd0, iti_o}, 64'h6);
    tick();
    check("R10 sticky refire", {60'd0, iti_o}, 64'h7);
    rd(12'h380, 2'd0, 64'h1FF_FFFC, "R10 sticky count");
    // R9 write clears overflow, ITI kept
    wr(12'h380, 64'h10);
    rd(12'h380, 2'd0, 64'h10, "R9 ovf cleared");
    check("R8 iti kept", {60'd0, iti_o}, 64'h7);
    wr(12'h080, 64'h70);
    check("R2 iti all clear", {60'd0, iti_o}, 64'h0);

    // R12 tick and write in same cycle
    cyc(1'b1, 12'h080, 64'h40, 1'b1);
    check("R12 write after tick", {60'd0, iti_o}, 64'h2);
    cyc(1'b1, 12'h3C0, 64'h7, 1'b1);
    rd(12'h3C0, 2'd0, 64'h7, "R12 ctr write wins");
    check("R12 iti", {60'd0, iti_o}, 64'h6);

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule